// File: doc/BRIEF.md
# Bus Address-Phase Timeout Monitor

This block watches the address tenure of a processor-side bus so that a missing slave cannot hang it. A transfer-start strobe opens a tenure, and a counter then runs against a programmable limit. If the address-acknowledge arrives in time, the tenure closes and nothing is recorded. If the limit is reached first, the monitor drives a one-cycle acknowledge of its own so the transfer can finish. It also raises a sticky timeout status bit and keeps the address of the failed transfer.

Transfers marked as bound for the PCI side are not timed, because the PCI master times them. The timer can also be switched off with its enable bit. The sticky status bit is routed to a level interrupt request, a level machine-check request, or both, according to two enable inputs. Software clears the status bit with a one-cycle clear strobe, which models a write of 1 to the bit.

Top module: `bus_addr_tmo_mon`

## Requirements
- R1: After reset, `aack_n_o` is high, and `tmo_stat_o`, `err_addr_o`, `irq_o` and `mchk_o` are all zero.
- R2: Call the rising edge that samples `ts_n_i` low and starts a tenure edge 0. If `aack_n_i` is not sampled low at edges 1 to P, `aack_n_o` goes low for exactly the one cycle that follows edge P. It is high in every other cycle.
- R3: P is captured at edge 0 from `tmo_sel_i`: value 0 gives 8, 1 gives 64, 2 gives 256 and 3 gives 1024 clocks.
- R4: If `aack_n_i` is sampled low at any edge from 1 to P, the tenure ends with no forced acknowledge and no change to `tmo_stat_o`.
- R5: On expiry, `tmo_stat_o` is set at edge P. If the status bit was clear, `err_addr_o` takes the `addr_i` value that was sampled at edge 0.
- R6: A start sampled while `pci_bound_i` is high, or while `tmo_en_i` is low, is not timed.
- R7: In any cycle in which `aack_n_i` is low, `aack_n_o` is high.
- R8: `tmo_stat_o` is sticky. `clr_i` sampled high at an edge clears it. An expiry at that same edge wins, and the bit stays set.
- R9: While `tmo_stat_o` is set, `err_addr_o` holds its value. The exception is an expiry at an edge where `clr_i` is high, which captures the new address.
- R10: `irq_o` equals `tmo_stat_o` AND `irq_en_i`, and `mchk_o` equals `tmo_stat_o` AND `mchk_en_i`. Both are levels.
- R11: A start strobe sampled while a tenure is being timed is ignored. The running count and the captured address are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ts_n_i | input | 1 | Transfer-start strobe, active low |
| aack_n_i | input | 1 | Address-acknowledge from the bus, active low |
| addr_i | input | ADDR_W | Transfer address, sampled with the start strobe |
| pci_bound_i | input | 1 | High when the transfer targets the PCI side |
| tmo_en_i | input | 1 | Timer enable |
| tmo_sel_i | input | 2 | Timeout period select |
| clr_i | input | 1 | Clear strobe for the status bit |
| irq_en_i | input | 1 | Routes the status bit to the interrupt request |
| mchk_en_i | input | 1 | Routes the status bit to the machine-check request |
| aack_n_o | output | 1 | Self-generated acknowledge, active low |
| tmo_stat_o | output | 1 | Sticky timeout status |
| err_addr_o | output | ADDR_W | Captured address of the timed-out transfer |
| irq_o | output | 1 | Interrupt request level |
| mchk_o | output | 1 | Machine-check request level |

## Verification
Every period select is tried with the acknowledge placed in several positions:
- never arriving;
- at the first edge;
- one edge before the limit;
- exactly at the limit;
- one edge after the limit.

The placements at the limit and just after it separate an off-by-one counter from a correct one. The late placement also shows whether the forced pulse is masked while a real acknowledge is present.

The same tenures are repeated with the PCI flag set and with the timer disabled, which confirms that those tenures are skipped. Separate sequences cover the following cases:
- a second start strobe in mid-tenure;
- back-to-back timeouts with no clear in between, which confirms that the address is frozen;
- a clear that lands on the expiry edge;
- all four combinations of the interrupt and machine-check enables.

// File: rtl/tmo_mon_pkg.sv
package tmo_mon_pkg;

  // Period in clocks for a given select code.
  function automatic int unsigned tmo_period(input logic [1:0] sel,
                                             input int unsigned p0,
                                             input int unsigned p1,
                                             input int unsigned p2,
                                             input int unsigned p3);
    case (sel)
      2'd0:    return p0;
      2'd1:    return p1;
      2'd2:    return p2;
      default: return p3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c,
                                       input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/tmo_tenure_timer.sv
module tmo_tenure_timer
  import tmo_mon_pkg::*;
#(
  parameter int unsigned P_SEL0 = 8,
  parameter int unsigned P_SEL1 = 64,
  parameter int unsigned P_SEL2 = 256,
  parameter int unsigned P_SEL3 = 1024,
  parameter int unsigned CNT_W  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ts_n_i,
  input  logic       aack_n_i,
  input  logic       pci_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       take_o,
  output logic       expire_o
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             start_seen;

  // A start strobe only opens a tenure while the timer is idle.
  assign start_seen = !ts_n_i && !busy_q;
  assign take_o     = start_seen && en_i && !pci_i;
  assign expire_o   = busy_q && aack_n_i && (cnt_q == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (take_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      lim_q  <= CNT_W'(tmo_period(sel_i, P_SEL0, P_SEL1, P_SEL2, P_SEL3) - 1);
    end else if (busy_q) begin
      if (!aack_n_i || expire_o) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R4: a real acknowledge closes the tenure
  a_r4_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !aack_n_i) |=> !busy_q);

  // R6: starts bound for PCI or with the timer off are skipped
  a_r6_skip_untimed: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && (pci_i || !en_i)) |=> !busy_q);

  // R11: the count keeps running through a repeated start strobe
  a_r11_count_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && aack_n_i && !expire_o) |=> (busy_q && cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/tmo_err_log.sv
module tmo_err_log #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              expire_i,
  input  logic              clr_i,
  input  logic              irq_en_i,
  input  logic              mchk_en_i,
  output logic              tmo_stat_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic              irq_o,
  output logic              mchk_o
);

  logic [ADDR_W-1:0] pend_addr_q;
  logic              stat_q;
  logic              cap_ok;

  // The captured address may be replaced while the bit is clear or being cleared.
  assign cap_ok = !stat_q || clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr_q <= '0;
    end else if (take_i) begin
      pend_addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= 1'b0;
      err_addr_o <= '0;
    end else if (expire_i) begin
      stat_q <= 1'b1;
      if (cap_ok) err_addr_o <= pend_addr_q;
    end else if (clr_i) begin
      stat_q <= 1'b0;
    end
  end

  assign tmo_stat_o = stat_q;
  assign irq_o      = stat_q && irq_en_i;
  assign mchk_o     = stat_q && mchk_en_i;

  // R5: expiry raises the status bit
  a_r5_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> tmo_stat_o);

  // R8: status holds without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_stat_o && !clr_i) |=> tmo_stat_o);

  // R9: captured address frozen while status is set
  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_stat_o && !clr_i) |=> $stable(err_addr_o));

endmodule

// File: rtl/tmo_ack_gen.sv
module tmo_ack_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic aack_n_i,
  output logic aack_n_o
);

  logic force_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= expire_i;
  end

  // Mask the forced pulse while a real acknowledge is on the bus.
  assign aack_n_o = !(force_q && aack_n_i);

  // R2: the forced acknowledge lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |=> !force_q);

endmodule

// File: rtl/bus_addr_tmo_mon.sv
module bus_addr_tmo_mon
  import tmo_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned P_SEL0 = 8,
  parameter int unsigned P_SEL1 = 64,
  parameter int unsigned P_SEL2 = 256,
  parameter int unsigned P_SEL3 = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_n_i,
  input  logic              aack_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pci_bound_i,
  input  logic              tmo_en_i,
  input  logic [1:0]        tmo_sel_i,
  input  logic              clr_i,
  input  logic              irq_en_i,
  input  logic              mchk_en_i,
  output logic              aack_n_o,
  output logic              tmo_stat_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic              irq_o,
  output logic              mchk_o
);

  localparam int unsigned P_MAX = max4(P_SEL0, P_SEL1, P_SEL2, P_SEL3);
  localparam int unsigned CNT_W = (P_MAX > 2) ? $clog2(P_MAX) : 1;

  logic take_w;
  logic expire_w;

  tmo_tenure_timer #(
    .P_SEL0(P_SEL0), .P_SEL1(P_SEL1), .P_SEL2(P_SEL2), .P_SEL3(P_SEL3),
    .CNT_W (CNT_W)
  ) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ts_n_i  (ts_n_i),
    .aack_n_i(aack_n_i),
    .pci_i   (pci_bound_i),
    .en_i    (tmo_en_i),
    .sel_i   (tmo_sel_i),
    .take_o  (take_w),
    .expire_o(expire_w)
  );

  tmo_err_log #(.ADDR_W(ADDR_W)) log_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take_w),
    .addr_i    (addr_i),
    .expire_i  (expire_w),
    .clr_i     (clr_i),
    .irq_en_i  (irq_en_i),
    .mchk_en_i (mchk_en_i),
    .tmo_stat_o(tmo_stat_o),
    .err_addr_o(err_addr_o),
    .irq_o     (irq_o),
    .mchk_o    (mchk_o)
  );

  tmo_ack_gen ack_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire_i(expire_w),
    .aack_n_i(aack_n_i),
    .aack_n_o(aack_n_o)
  );

  // R7: never drive the acknowledge together with a real one
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !aack_n_i |-> aack_n_o);

  // R4: a sampled real acknowledge never leads to a new log entry
  a_r4_ack_blocks_log: assert property (@(posedge clk) disable iff (!rst_n)
    !aack_n_i |=> !$rose(tmo_stat_o));

endmodule

// File: tb/bus_addr_tmo_mon_tb_top.sv
module bus_addr_tmo_mon_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts_n = 1'b1, aack_n = 1'b1, pci = 1'b0, en = 1'b1, clr = 1'b0;
  logic        irq_en = 1'b0, mchk_en = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] addr = '0;
  logic        aack_n_o, stat_o, irq_o, mchk_o;
  logic [31:0] err_addr_o;

  int n_vec = 0, n_bad = 0;
  bit m_stat = 0;
  logic [31:0] m_addr = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_addr_tmo_mon dut_i (
    .clk(clk), .rst_n(rst_n), .ts_n_i(ts_n), .aack_n_i(aack_n), .addr_i(addr),
    .pci_bound_i(pci), .tmo_en_i(en), .tmo_sel_i(sel), .clr_i(clr),
    .irq_en_i(irq_en), .mchk_en_i(mchk_en), .aack_n_o(aack_n_o),
    .tmo_stat_o(stat_o), .err_addr_o(err_addr_o), .irq_o(irq_o), .mchk_o(mchk_o)
  );

  function automatic int per_of(input logic [1:0] s);
    return 8 << (s == 0 ? 0 : (s == 1 ? 3 : (s == 2 ? 5 : 7)));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_levels(input string req);
    check(stat_o == m_stat, req, "status", stat_o, m_stat);
    check(err_addr_o == m_addr, req, "err_addr", err_addr_o, m_addr);
    check(irq_o == (m_stat && irq_en), "R10", "irq", irq_o, m_stat && irq_en);
    check(mchk_o == (m_stat && mchk_en), "R10", "mchk", mchk_o, m_stat && mchk_en);
  endtask

  // One tenure starting at edge 0; ack/retrig/clr give edge numbers (0 = none).
  task automatic run_case(input logic [1:0] s, input int ack_e, input bit is_pci,
                          input bit is_en, input int retrig, input int clr_e,
                          input logic [31:0] a);
    int p = per_of(s);
    bit tmo = is_en && !is_pci && (ack_e == 0 || ack_e > p);
    @(negedge clk);
    ts_n = 1'b0; addr = a; sel = s; pci = is_pci; en = is_en; clr = 1'b0; aack_n = 1'b1;
    @(negedge clk);
    ts_n = (retrig == 1) ? 1'b0 : 1'b1; addr = a ^ 32'h5555_AAAA;
    aack_n = (ack_e == 1) ? 1'b0 : 1'b1; clr = (clr_e == 1);
    sel = ~s;
    for (int j = 1; j <= p + 2; j++) begin
      bit clr_now = clr;
      @(negedge clk);
      if (tmo && j == p) begin
        if (!m_stat || clr_now) m_addr = a;
        m_stat = 1;
      end else if (clr_now) m_stat = 0;
      // R2 R3 R4 R6: forced acknowledge only in the cycle after edge P
      check(aack_n_o == !(tmo && j == p), tmo ? "R2" : (is_en && !is_pci ? "R4" : "R6"),
            "aack_n_o", aack_n_o, !(tmo && j == p));
      check(stat_o == m_stat, "R8", "status", stat_o, m_stat);
      aack_n = (ack_e == j + 1) ? 1'b0 : 1'b1;
      clr    = (clr_e == j + 1);
      ts_n   = (retrig == j + 1) ? 1'b0 : 1'b1;
      if (tmo && j == p && ack_e == p + 1) begin
        #1;
        check(aack_n_o == 1'b1, "R7", "overlap", aack_n_o, 1);
      end
    end
    aack_n = 1'b1; clr = 1'b0; ts_n = 1'b1;
    @(negedge clk);
    check_levels("R5");
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; m_stat = 0;
    check_levels("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(aack_n_o == 1'b1, "R1", "aack_n_o", aack_n_o, 1);
    check(stat_o == 1'b0, "R1", "status", stat_o, 0);
    check(err_addr_o == 0, "R1", "err_addr", err_addr_o, 0);
    check(irq_o == 1'b0 && mchk_o == 1'b0, "R1", "irq/mchk", {irq_o, mchk_o}, 0);
    rst_n = 1'b1;

    // R3 sweep over every select, ack placement and target
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k++) begin
        for (int pc = 0; pc < 2; pc++) begin
          int p = per_of(s[1:0]);
          int ack_e = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? p - 1 : (k == 3) ? p : p + 1;
          irq_en = k[0]; mchk_en = k[1];
          run_case(s[1:0], ack_e, pc[0], 1'b1, 0, 0,
                   32'hA000_0000 | (s << 12) | (k << 4) | pc);
          do_clear();
        end
      end
      // R6: timer disabled
      run_case(s[1:0], 0, 1'b0, 1'b0, 0, 0, 32'hD15A_0000 | s);
      do_clear();
    end

    // R11: second start strobe mid-tenure is ignored
    irq_en = 1; mchk_en = 0;
    run_case(2'd0, 0, 1'b0, 1'b1, 3, 0, 32'h1111_0001);
    do_clear();

    // R9: back-to-back timeouts without clear keep the first address
    irq_en = 0; mchk_en = 1;
    run_case(2'd0, 0, 1'b0, 1'b1, 0, 0, 32'h2222_0001);
    run_case(2'd0, 0, 1'b0, 1'b1, 0, 0, 32'h2222_0002);
    // R8: clear on the expiry edge keeps status, takes new address (R9)
    run_case(2'd0, 0, 1'b0, 1'b1, 0, 8, 32'h3333_0003);
    // R8: clear mid-tenure, then fresh expiry
    run_case(2'd1, 0, 1'b0, 1'b1, 0, 2, 32'h4444_0004);
    irq_en = 1; mchk_en = 1;
    @(negedge clk);
    check_levels("R10");
    do_clear();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule